// File: doc/BRIEF.md
# North Bridge Control Register File

This block is the control register bank of a system north bridge. It holds 28 words of 32 bits, and software reaches them with word accesses only. The words cover power-on and general configuration, I/O and memory timing, PCI window mapping, GPIO data and enables, interrupt steering, four mailboxes and PCI cache and status words. A host-side bus adapter presents one access per cycle as a word index, a write flag and a data word. Read data is returned combinationally for the index on the address input.

Two words are not plain storage. Software never writes the interrupt-enable word directly. It sets bits through a write-one-to-set alias and clears bits through a write-one-to-clear alias, and each alias also keeps the last value written to it. The general-configuration word watches its bit 2. When a write moves that bit from 0 to 1, the block raises a one-cycle system reset request. The interrupt-edge and interrupt-polarity words drive output ports so that the interrupt logic next to the bank can use them.

Top module: `nb_ctrl_regs`

## Requirements
- R1: After rst_ni is asserted, every word reads its default. The byte offset of a word is 4 × index. The defaults are 0x00000C40 at 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and at 0x20, 0x00000008 at 0x68 and 0x10000000 at 0x6C. Every other word resets to zero.
- R2: A write to any plain word stores all 32 bits at the clock edge, and the stored word is then read back at the same offset. The plain words are every offset from 0x00 to 0x6C except 0x38 and 0x3C.
- R3: A write to 0x30 stores the written word at 0x30 and ORs it into the interrupt-enable word at 0x38 at the same edge.
- R4: A write to 0x34 stores the written word at 0x34 and clears, at the same edge, every bit of 0x38 that is 1 in the written word.
- R5: Writes to 0x38 (interrupt enable) and to 0x3C (interrupt status) change nothing. The status word at 0x3C always reads zero.
- R6: sys_rst_req_o is high for exactly the one cycle after a write to 0x04 whose data has bit 2 set while the stored bit 2 was clear. A write to 0x04 that leaves bit 2 at 1, or clears it, produces no request.
- R7: Word indices 28 to 31 (byte offsets 0x70 to 0x7C) are unmapped. A write to one of them changes no register, and a read of one returns zero.
- R8: int_edge_o always equals the word at 0x24, and int_pol_o always equals the word at 0x2C.
- R9: acc_rdata_o follows acc_addr_i combinationally within the same cycle, whether or not an access is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 5 | Word index (byte offset / 4) |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for acc_addr_i |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| int_edge_o | output | 32 | Interrupt edge-select word |
| int_pol_o | output | 32 | Interrupt polarity word |

## Verification
A corrupted stored word shows up on acc_rdata_o as soon as its index is presented, in the same cycle. For the edge and polarity words it shows on their output ports at once, with no read needed. A wrong interrupt-enable update after a set or clear write is visible when 0x38 is read in the next cycle. A lost or doubled reset request shows on sys_rst_req_o in the cycle right after the write to 0x04. The bench compares every output against a behavioural model on every cycle, so any such fault is reported in the first cycle it reaches a port.

// File: rtl/nb_regs_pkg.sv
package nb_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 28;

  localparam int IDX_PWRON   = 0;
  localparam int IDX_GENCFG  = 1;
  localparam int IDX_IODEV   = 2;
  localparam int IDX_SDRAM   = 3;
  localparam int IDX_PCIMAP  = 4;
  localparam int IDX_GPIO_D  = 7;
  localparam int IDX_GPIO_E  = 8;
  localparam int IDX_INT_EDG = 9;
  localparam int IDX_INT_POL = 11;
  localparam int IDX_EN_SET  = 12;
  localparam int IDX_EN_CLR  = 13;
  localparam int IDX_INT_EN  = 14;
  localparam int IDX_INT_ISR = 15;
  localparam int IDX_DQCFG   = 26;
  localparam int IDX_MEMSZ   = 27;

  localparam int RST_BIT = 2;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t reset_value(input int idx);
    case (idx)
      IDX_PWRON:  return 32'h0000_0C40;
      IDX_GENCFG: return 32'h0000_1384;
      IDX_IODEV:  return 32'h2BFF_8010;
      IDX_SDRAM:  return 32'h255E_0091;
      IDX_PCIMAP: return 32'h0000_6140;
      IDX_GPIO_D: return 32'h0000_01FF;
      IDX_GPIO_E: return 32'h0000_01FF;
      IDX_DQCFG:  return 32'h0000_0008;
      IDX_MEMSZ:  return 32'h1000_0000;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/nb_wr_decode.sv
module nb_wr_decode #(
  parameter int IDX_W  = 5,
  parameter int NWORDS = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NWORDS-1:0] stb_o
);
  always_comb begin
    stb_o = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (valid_i && write_i && (int'(idx_i) == i)) stb_o[i] = 1'b1;
    end
  end

  p_onehot_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
  p_no_stb_unmapped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_i) >= NWORDS) |-> (stb_o == '0));
endmodule

// File: rtl/nb_word_reg.sv
module nb_word_reg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/nb_int_enable.sv
module nb_int_enable #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= '0;
    else if (set_i)  en_o <= en_o | bits_i;
    else if (clr_i)  en_o <= en_o & ~bits_i;
  end

  p_set_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((en_o & $past(bits_i)) == $past(bits_i)));
  p_set_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((en_o & $past(en_o)) == $past(en_o)));
  p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((en_o & $past(bits_i)) == '0));
  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_o));
endmodule

// File: rtl/nb_reset_pulse.sv
module nb_reset_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= we_i && !old_bit_i && new_bit_i;
  end

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

// File: rtl/nb_ctrl_regs.sv
module nb_ctrl_regs
  import nb_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              sys_rst_req_o,
  output logic [DATA_W-1:0] int_edge_o,
  output logic [DATA_W-1:0] int_pol_o
);
  localparam int NUM_SLOTS = 1 << ADDR_W;

  logic [NUM_WORDS-1:0] wr_stb;
  word_t                word_q [NUM_SLOTS];

  nb_wr_decode #(.IDX_W(ADDR_W), .NWORDS(NUM_WORDS)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .idx_i   (acc_addr_i),
    .stb_o   (wr_stb)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i >= NUM_WORDS) begin : g_hole
      assign word_q[i] = '0;
    end else if (i == IDX_INT_EN) begin : g_en
      nb_int_enable #(.W(DATA_W)) u_en (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (wr_stb[IDX_EN_SET]),
        .clr_i  (wr_stb[IDX_EN_CLR]),
        .bits_i (acc_wdata_i),
        .en_o   (word_q[i])
      );
      p_en_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb[i] |=> $stable(word_q[i]));
    end else if (i == IDX_INT_ISR) begin : g_isr
      assign word_q[i] = '0;
      p_isr_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb[i] |=> (word_q[i] == '0));
    end else begin : g_word
      nb_word_reg #(.W(DATA_W), .RESET_VAL(reset_value(i))) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_stb[i]),
        .d_i    (acc_wdata_i),
        .q_o    (word_q[i])
      );
    end
  end

  nb_reset_pulse u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_stb[IDX_GENCFG]),
    .old_bit_i (word_q[IDX_GENCFG][RST_BIT]),
    .new_bit_i (acc_wdata_i[RST_BIT]),
    .req_o     (sys_rst_req_o)
  );

  assign acc_rdata_o = word_q[acc_addr_i];
  assign int_edge_o  = word_q[IDX_INT_EDG];
  assign int_pol_o   = word_q[IDX_INT_POL];

  p_req_bit_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> word_q[IDX_GENCFG][RST_BIT]);
  p_req_from_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(wr_stb[IDX_GENCFG]));
  p_unmapped_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && (int'(acc_addr_i) >= NUM_WORDS))
      |=> ($stable(int_edge_o) && $stable(int_pol_o) && !sys_rst_req_o));
endmodule

// File: tb/nb_ctrl_regs_test.sv
module nb_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, w = 1'b0;
  logic [4:0]  a = '0;
  logic [31:0] d = '0;
  logic [31:0] rdata, edge_w, pol_w;
  logic        rreq;

  int vectors = 0, fails = 0;
  bit done = 0;
  string phase = "";

  logic [31:0] mdl [0:31];
  logic        exp_req;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  nb_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_write_i(w),
    .acc_addr_i(a), .acc_wdata_i(d), .acc_rdata_o(rdata),
    .sys_rst_req_o(rreq), .int_edge_o(edge_w), .int_pol_o(pol_w)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0000_0C40;  1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
      4: return 32'h0000_6140;  7: return 32'h0000_01FF;
      8: return 32'h0000_01FF; 26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mdl[i] <= dflt(i);
      exp_req <= 1'b0;
    end else begin
      exp_req <= 1'b0;
      if (v && w) begin
        case (int'(a))
          1:  begin exp_req <= !mdl[1][2] && d[2]; mdl[1] <= d; end
          12: begin mdl[12] <= d; mdl[14] <= mdl[14] | d; end
          13: begin mdl[13] <= d; mdl[14] <= mdl[14] & ~d; end
          14, 15: ;
          default: if (int'(a) < 28) mdl[a] <= d;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int idx);
    if (phase != "") return phase;
    if (idx >= 28) return "R7";
    if (idx == 12 || idx == 14) return "R3";
    if (idx == 13) return "R4";
    if (idx == 15) return "R5";
    return "R2";
  endfunction

  task automatic compare_all();
    chk(tag_of(int'(a)), rdata, (int'(a) >= 28) ? 32'h0 : mdl[a]);
    chk("R6", {31'b0, rreq}, {31'b0, exp_req});
    chk("R8", edge_w, mdl[9]);
    chk("R8", pol_w, mdl[11]);
  endtask

  task automatic step(input logic vv, input logic ww, input int aa, input logic [31:0] dd);
    @(negedge clk);
    compare_all();
    v = vv; w = ww; a = aa[4:0]; d = dd;
  endtask

  task automatic wr(input int aa, input logic [31:0] dd); step(1, 1, aa, dd); endtask
  task automatic rd(input int aa); step(1, 0, aa, 32'h0); endtask

  task automatic peek(input int aa);
    a = aa[4:0];
    #1;
    chk("R9", rdata, (aa >= 28) ? 32'h0 : mdl[aa]);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #200_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: defaults after reset
    phase = "R1";
    for (int i = 0; i < 32; i++) rd(i);
    rd(0);
    phase = "";
    // R2: plain words store and read back
    for (int i = 0; i < 28; i++) begin
      if (i == 1 || (i >= 12 && i <= 15)) continue;
      lfsr = nxt(lfsr);
      wr(i, lfsr);
      rd(i);
    end
    // R3 / R4: set and clear aliases
    wr(12, 32'hF0F0_00FF); rd(14);
    wr(12, 32'h0F00_0000); rd(14);
    wr(13, 32'h0000_00F0); rd(14); rd(13); rd(12);
    wr(13, 32'h0000_0000); rd(14);
    // R5: direct writes to enable and status ignored
    wr(14, 32'hFFFF_FFFF); rd(14);
    wr(15, 32'h1234_5678); rd(15);
    // R6: reset request on rising bit 2
    wr(1, 32'h0000_1380); rd(1);
    wr(1, 32'h0000_1384); rd(1);
    wr(1, 32'h0000_1384); rd(1);
    wr(1, 32'h0000_0000); rd(1);
    wr(1, 32'hFFFF_FFFF); step(0, 0, 1, 0); rd(1);
    // R7: unmapped holes
    for (int i = 28; i < 32; i++) begin wr(i, 32'hDEAD_BEEF); rd(i); end
    // R8: exported words
    wr(9, 32'h0000_00A5); wr(11, 32'h5A00_0000); rd(9); rd(11);
    // R9: combinational read on address change
    for (int i = 0; i < 32; i += 3) peek(i);
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0], lfsr[1], int'(lfsr[8:4]), nxt(lfsr) ^ {lfsr[15:0], lfsr[31:16]});
    end
    step(0, 0, 0, 0);
    step(0, 0, 14, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule